// File: doc/BRIEF.md
# Subchannel Engine Binding Router

This block sits behind a command-stream decoder. Each accepted write carries a 13-bit method number, a 3-bit subchannel and a 32-bit value. A run-time table holds one entry per subchannel. In-band bind writes fill that table, and the table steers every ordinary register write to the engine port currently attached to its subchannel. There are three engine ports: 2D, 3D and compute. They share one method bus and one value bus, and each port has its own write strobe.

Method 0 is the bind command. It writes the value into the table as an engine class identifier. The rest of the low method range is reserved and is consumed inside the block. Writes that cannot be delivered are discarded. Each such case sets its own sticky error bit, and the bit stays set until a clear pulse arrives.

All outputs are registered. A write presented in cycle N shows its strobe or its error bit in cycle N+1.

Top module: `subch_router`

## Requirements
- R1: After reset no subchannel is bound, eng_we_o is 0 and err_o is 0.
- R2: A write with method 0 binds its subchannel to the class given by the full 32-bit value, and it raises no strobe. 0x0000902D selects 2D, 0x0000B197 selects 3D and 0x0000B1C0 selects compute. Any other value is stored as "no port".
- R3: A write with a method from 1 to 0xFF is dropped without a strobe and sets err_o[2].
- R4: A write with method 0x100 or above, on a subchannel bound to an engine with a port, pulses eng_we_o one cycle later. Bit 0 is 2D, bit 1 is 3D and bit 2 is compute. In the same cycle eng_method_o and eng_data_o carry the write's method and value.
- R5: Each forwarded write produces exactly one strobe cycle, and at most one eng_we_o bit is set in any cycle.
- R6: A bind to an already bound subchannel sets err_o[0] and leaves the existing binding unchanged.
- R7: A forwarded write to an unbound subchannel sets err_o[1] and is discarded.
- R8: A forwarded write to a subchannel bound to a class with no port sets err_o[3] and is discarded. This covers 0xA140, 0xB0B5 and unknown values.
- R9: Error bits are sticky until err_clr_i is high. If a new error arrives in the same cycle as a clear, the error bit is set.
- R10: Each subchannel's binding is independent of every other subchannel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write tuple valid |
| wr_method_i | input | 13 | Method number |
| wr_subch_i | input | 3 | Subchannel |
| wr_data_i | input | 32 | Write value |
| err_clr_i | input | 1 | Clears sticky error bits |
| eng_we_o | output | 3 | Per-engine write strobe (0 = 2D, 1 = 3D, 2 = compute) |
| eng_method_o | output | 13 | Method on the shared engine bus |
| eng_data_o | output | 32 | Value on the shared engine bus |
| err_o | output | 4 | Sticky errors: 0 rebind, 1 unbound, 2 reserved, 3 no port |

## Verification
The vector walk binds four subchannels to 2D, 3D, compute and a portless class. It then forwards writes through each of them, using methods at the 0x100 edge and at the top of the range. This separates correct steering from a strobe landing on the wrong port, and a correct bus value from a stale one.

Reserved methods 5 and 0xFF test the reserved-range edge. A second bind to subchannel 0 is followed by a forward through it, which separates a rejected rebind from a silent overwrite.

Directed tests cover the remaining cases:
- sticky persistence;
- an error arriving together with a clear;
- a reset in mid-run that must drop every binding.

// File: rtl/subch_router_pkg.sv
package subch_router_pkg;
  localparam int METHOD_W  = 13;
  localparam int SUBCH_W   = 3;
  localparam int DATA_W    = 32;
  localparam int N_ENG     = 3;
  localparam int SEL_W     = $clog2(N_ENG + 1);
  localparam int RSVD_LIM  = 'h100;
  localparam int N_ERR     = 4;

  localparam logic [DATA_W-1:0] CLS_2D  = 32'h0000_902D;
  localparam logic [DATA_W-1:0] CLS_3D  = 32'h0000_B197;
  localparam logic [DATA_W-1:0] CLS_CMP = 32'h0000_B1C0;

  localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(N_ENG);

  localparam int ERR_REBIND  = 0;
  localparam int ERR_UNBOUND = 1;
  localparam int ERR_RSVD    = 2;
  localparam int ERR_NOPORT  = 3;

  function automatic logic [SEL_W-1:0] class_to_sel(input logic [DATA_W-1:0] cls);
    case (cls)
      CLS_2D:  class_to_sel = SEL_W'(0);
      CLS_3D:  class_to_sel = SEL_W'(1);
      CLS_CMP: class_to_sel = SEL_W'(2);
      default: class_to_sel = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/subch_bind_table.sv
module subch_bind_table
  import subch_router_pkg::*;
#(
  parameter int N_SUBCH = 8,
  localparam int IDX_W  = $clog2(N_SUBCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bind_we_i,
  input  logic [IDX_W-1:0] bind_idx_i,
  input  logic [SEL_W-1:0] bind_sel_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [SEL_W-1:0] rd_sel_o
);
  logic [N_SUBCH-1:0] vld_q;
  logic [SEL_W-1:0]   sel_q [N_SUBCH];

  for (genvar g = 0; g < N_SUBCH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        sel_q[g] <= SEL_NONE;
      end else if (bind_we_i && bind_idx_i == IDX_W'(g) && !vld_q[g]) begin
        vld_q[g] <= 1'b1;
        sel_q[g] <= bind_sel_i;
      end
    end

    // R6: an entry once valid keeps its binding
    p_bind_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[g] |=> (vld_q[g] && $stable(sel_q[g])));
  end

  assign rd_valid_o = vld_q[rd_idx_i];
  assign rd_sel_o   = sel_q[rd_idx_i];
endmodule

// File: rtl/subch_route.sv
module subch_route
  import subch_router_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fwd_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [METHOD_W-1:0] method_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [N_ENG-1:0]    we_o,
  output logic [METHOD_W-1:0] method_o,
  output logic [DATA_W-1:0]   data_o
);
  for (genvar e = 0; e < N_ENG; e++) begin : g_we
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) we_o[e] <= 1'b0;
      else         we_o[e] <= fwd_i && (sel_i == SEL_W'(e));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      method_o <= '0;
      data_o   <= '0;
    end else if (fwd_i) begin
      method_o <= method_i;
      data_o   <= data_i;
    end
  end

  p_we_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));
  p_we_from_fwd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_i |=> (we_o == '0));
endmodule

// File: rtl/subch_err_status.sv
module subch_err_status
  import subch_router_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ERR-1:0] set_i,
  input  logic             clr_i,
  output logic [N_ERR-1:0] err_o
);
  for (genvar b = 0; b < N_ERR; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       err_o[b] <= 1'b0;
      else if (set_i[b]) err_o[b] <= 1'b1;
      else if (clr_i)    err_o[b] <= 1'b0;
    end

    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o[b] && !clr_i) |=> err_o[b]);
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> err_o[b]);
  end
endmodule

// File: rtl/subch_router.sv
module subch_router
  import subch_router_pkg::*;
#(
  parameter int N_SUBCH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [12:0]         wr_method_i,
  input  logic [2:0]          wr_subch_i,
  input  logic [31:0]         wr_data_i,
  input  logic                err_clr_i,
  output logic [2:0]          eng_we_o,
  output logic [12:0]         eng_method_o,
  output logic [31:0]         eng_data_o,
  output logic [3:0]          err_o
);
  localparam logic [METHOD_W-1:0] RSVD_M = METHOD_W'(RSVD_LIM);
  localparam int IDX_W = $clog2(N_SUBCH);

  logic             is_bind, is_rsvd, is_fwd, fwd_go, bind_we;
  logic             rd_valid;
  logic [SEL_W-1:0] rd_sel;
  logic [N_ERR-1:0] err_set;

  assign is_bind = wr_valid_i && (wr_method_i == '0);
  assign is_rsvd = wr_valid_i && (wr_method_i != '0) && (wr_method_i < RSVD_M);
  assign is_fwd  = wr_valid_i && (wr_method_i >= RSVD_M);
  assign bind_we = is_bind && !rd_valid;
  assign fwd_go  = is_fwd && rd_valid && (rd_sel != SEL_NONE);

  always_comb begin
    err_set              = '0;
    err_set[ERR_REBIND]  = is_bind && rd_valid;
    err_set[ERR_UNBOUND] = is_fwd && !rd_valid;
    err_set[ERR_RSVD]    = is_rsvd;
    err_set[ERR_NOPORT]  = is_fwd && rd_valid && (rd_sel == SEL_NONE);
  end

  subch_bind_table #(.N_SUBCH(N_SUBCH)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bind_we_i  (bind_we),
    .bind_idx_i (IDX_W'(wr_subch_i)),
    .bind_sel_i (class_to_sel(wr_data_i)),
    .rd_idx_i   (IDX_W'(wr_subch_i)),
    .rd_valid_o (rd_valid),
    .rd_sel_o   (rd_sel)
  );

  subch_route u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fwd_i    (fwd_go),
    .sel_i    (rd_sel),
    .method_i (wr_method_i),
    .data_i   (wr_data_i),
    .we_o     (eng_we_o),
    .method_o (eng_method_o),
    .data_o   (eng_data_o)
  );

  subch_err_status u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (err_clr_i),
    .err_o  (err_o)
  );

  p_bind_no_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_method_i == '0) |=> (eng_we_o == '0));
  p_rsvd_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_method_i != '0 && wr_method_i < RSVD_M)
      |=> (eng_we_o == '0 && err_o[ERR_RSVD]));
  p_fwd_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_we_o != '0) |-> ($past(wr_valid_i) && eng_method_o == $past(wr_method_i)
                          && eng_data_o == $past(wr_data_i)));
  p_fwd_method_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_we_o != '0) |-> (eng_method_o >= RSVD_M));
endmodule

// File: tb/subch_router_bench.sv
module subch_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_method = '0;
  logic [2:0]  wr_subch = '0;
  logic [31:0] wr_data = '0;
  logic        err_clr = 1'b0;
  logic [2:0]  eng_we;
  logic [12:0] eng_method;
  logic [31:0] eng_data;
  logic [3:0]  err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  subch_router u_subch_router (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_valid_i   (wr_valid),
    .wr_method_i  (wr_method),
    .wr_subch_i   (wr_subch),
    .wr_data_i    (wr_data),
    .err_clr_i    (err_clr),
    .eng_we_o     (eng_we),
    .eng_method_o (eng_method),
    .eng_data_o   (eng_data),
    .err_o        (err)
  );

  // {method, subch, data, exp_we, exp_err}
  localparam int NV = 17;
  localparam logic [54:0] VEC [NV] = '{
    {13'h000, 3'd0, 32'h0000_902D, 3'b000, 4'b0000}, // R2 bind 2D
    {13'h000, 3'd1, 32'h0000_B197, 3'b000, 4'b0000}, // R2 bind 3D
    {13'h000, 3'd2, 32'h0000_B1C0, 3'b000, 4'b0000}, // R2 bind compute
    {13'h000, 3'd3, 32'h0000_A140, 3'b000, 4'b0000}, // R2 bind portless
    {13'h100, 3'd0, 32'hDEAD_0001, 3'b001, 4'b0000}, // R4 2D
    {13'h1FFF,3'd1, 32'hDEAD_0002, 3'b010, 4'b0000}, // R4 3D
    {13'h200, 3'd2, 32'hDEAD_0003, 3'b100, 4'b0000}, // R4 compute
    {13'h104, 3'd3, 32'hDEAD_0004, 3'b000, 4'b1000}, // R8
    {13'h104, 3'd4, 32'hDEAD_0005, 3'b000, 4'b0010}, // R7
    {13'h005, 3'd0, 32'hDEAD_0006, 3'b000, 4'b0100}, // R3
    {13'h0FF, 3'd1, 32'hDEAD_0007, 3'b000, 4'b0100}, // R3 edge
    {13'h000, 3'd0, 32'h0000_B197, 3'b000, 4'b0001}, // R6 rebind
    {13'h300, 3'd0, 32'hDEAD_0008, 3'b001, 4'b0000}, // R6 binding kept
    {13'h000, 3'd5, 32'h0000_1234, 3'b000, 4'b0000}, // R2 unknown class
    {13'h180, 3'd5, 32'hDEAD_0009, 3'b000, 4'b1000}, // R8 unknown
    {13'h000, 3'd6, 32'h0000_B0B5, 3'b000, 4'b0000}, // R10 bind s6
    {13'h180, 3'd6, 32'hDEAD_000A, 3'b000, 4'b1000}  // R8 dma class
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [12:0] m, input logic [2:0] s, input logic [31:0] d,
                       input logic clr);
    @(negedge clk);
    wr_valid = 1'b1; wr_method = m; wr_subch = s; wr_data = d; err_clr = clr;
    @(negedge clk);
    wr_valid = 1'b0; err_clr = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 we", 64'(eng_we), 64'(0));
    check("R1 err", 64'(err), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 err after release", 64'(err), 64'(0));

    for (int i = 0; i < NV; i++) begin
      clear_err();
      apply(VEC[i][54:42], VEC[i][41:39], VEC[i][38:7], 1'b0);
      check($sformatf("R4/R2 we vec%0d", i), 64'(eng_we), 64'(VEC[i][6:4]));
      check($sformatf("R3/R6/R7/R8 err vec%0d", i), 64'(err), 64'(VEC[i][3:0]));
      if (VEC[i][6:4] != 3'b000) begin
        check($sformatf("R4 method vec%0d", i), 64'(eng_method), 64'(VEC[i][54:42]));
        check($sformatf("R4 data vec%0d", i), 64'(eng_data), 64'(VEC[i][38:7]));
      end
      @(negedge clk);
      check($sformatf("R5 single pulse vec%0d", i), 64'(eng_we), 64'(0));
    end

    // R9 sticky, then clear, then clear together with a new error
    clear_err();
    apply(13'h010, 3'd7, 32'h0, 1'b0);
    repeat (4) @(negedge clk);
    check("R9 sticky", 64'(err), 64'h4);
    clear_err();
    check("R9 cleared", 64'(err), 64'h0);
    apply(13'h020, 3'd7, 32'h0, 1'b1);
    check("R9 set wins over clear", 64'(err), 64'h4);

    // R10 s7 still unbound after neighbours were bound
    clear_err();
    apply(13'h400, 3'd7, 32'h1, 1'b0);
    check("R10 s7 unbound", 64'(err), 64'h2);

    // R1 reset drops bindings
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 err in reset", 64'(err), 64'h0);
    rst_n = 1'b1;
    apply(13'h100, 3'd0, 32'h5, 1'b0);
    check("R1 s0 unbound after reset we", 64'(eng_we), 64'h0);
    check("R1 s0 unbound after reset err", 64'(err), 64'h2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule